// File: doc/BRIEF.md
# Pixel-to-Byte Write Sequencer

This block sits between a pixel-rate capture stage and a byte-wide FIFO write port. Each pixel word, 24 bits by default, arrives with a valid qualifier on a pixel clock. The block cuts the word into three bytes and writes them to the FIFO one after another. It runs on a fast clock that is four times the pixel rate and phase-aligned to the pixel clock, so every pixel period has four fast-clock slots. The nominal rates are a pixel clock near 33 MHz and a fast clock near 133 MHz.

The pixel clock enters as a plain input and is sampled on the fast clock. The first rising edge seen after reset fixes the slot phase. The fast-clock cycle in which the pixel clock rises is the idle slot. In that slot the word and its valid bit are latched into a holding register and the FIFO strobe stays low. The three slots after it each present one byte, most significant first, and strobe only if the latched valid bit was set. Data and strobe come only from registers, so the FIFO captures them on a rising fast-clock edge.

Top module: `pix_byte_seq`

## Requirements
- R1: The bytes of a latched word come out most significant first: bits 23:16, then 15:8, then 7:0. They appear in the three fast cycles that follow the idle slot, and each is captured on the rising edge that ends its cycle.
- R2: A valid pixel gives exactly three consecutive strobe cycles. The fourth slot of every pixel period has no strobe.
- R3: The idle slot is the fast cycle in which the sampled pixel clock is high and was low in the cycle before. `wr_en_o` is never high in that cycle.
- R4: Word and valid are sampled only in the idle slot. Changes on `pix_data_i` or `pix_valid_i` during the three byte slots have no effect on the bytes written.
- R5: If `pix_valid_i` is low in the idle slot, none of the three byte slots of that period asserts `wr_en_o`.
- R6: While `rst_ni` is low, `wr_en_o` and `wr_data_o` are 0. After release nothing is written until a low-to-high pixel-clock transition is seen. A pixel clock that is already high when reset is released does not count as a rising edge.
- R7: Once aligned, the slot counter free-runs modulo four and stays aligned until the next reset.
- R8: `wr_data_o` is all zeros in every cycle where `wr_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast byte clock, four times the pixel rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_clk_i | input | 1 | Pixel clock, sampled as a phase reference |
| pix_data_i | input | 24 | Pixel word |
| pix_valid_i | input | 1 | Pixel qualifier, sampled in the idle slot |
| wr_data_o | output | 8 | Byte to the FIFO write port |
| wr_en_o | output | 1 | FIFO write strobe |

## Verification
Every cycle, the assertions check four things. No strobe appears in a cycle where the pixel clock has just risen. The first byte of each burst equals the top byte of the word present in the idle slot. A burst starts only after a valid idle slot. A burst lasts no longer than three cycles. They also check that alignment, once reached, is kept. Only the bench scenarios can show the rest: the full byte order, that junk driven during the byte slots has no effect, that periods with valid low write nothing, and that a reset released while the pixel clock is high is handled. The bench also checks that the slot phase realigns when the pixel phase shifts after a reset.

// File: rtl/pixseq_pkg.sv
package pixseq_pkg;
  parameter int PIX_W_DEF  = 24;
  parameter int BYTE_W_DEF = 8;

  function automatic int bytes_per_pix(input int pix_w, input int byte_w);
    return pix_w / byte_w;
  endfunction
endpackage

// File: rtl/pixseq_slot_timer.sv
module pixseq_slot_timer #(
  parameter int SLOTS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_clk_i,
  output logic              locked_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              capture_o
);
  logic              pclk_q;
  logic              locked_q;
  logic [SLOT_W-1:0] slot_q;
  logic              rise;

  assign rise = pix_clk_i & ~pclk_q;

  // pclk_q resets high: a pixel clock already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pclk_q <= 1'b1;
    else         pclk_q <= pix_clk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      slot_q   <= '0;
    end else if (!locked_q) begin
      if (rise) begin
        locked_q <= 1'b1;
        slot_q   <= SLOT_W'(1);
      end
    end else begin
      slot_q <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
    end
  end

  assign locked_o  = locked_q;
  assign slot_o    = slot_q;
  assign capture_o = locked_q ? (slot_q == '0) : rise;

  p_lock_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
endmodule

// File: rtl/pixseq_hold.sv
module pixseq_hold #(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic [PIX_W-1:0] pix_data_i,
  input  logic             pix_valid_i,
  output logic [PIX_W-1:0] data_o,
  output logic             valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      valid_o <= 1'b0;
    end else if (capture_i) begin
      data_o  <= pix_data_i;
      valid_o <= pix_valid_i;
    end
  end
endmodule

// File: rtl/pixseq_byte_sel.sv
module pixseq_byte_sel #(
  parameter int PIX_W     = 24,
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 3,
  parameter int SLOT_W    = 2
) (
  input  logic              locked_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [PIX_W-1:0]  data_i,
  input  logic              valid_i,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_en_o
);
  logic [BYTE_W-1:0] sel;

  // slot k (1..NUM_BYTES) carries byte NUM_BYTES-k, MSB first
  always_comb begin
    sel = '0;
    for (int b = 0; b < NUM_BYTES; b++) begin
      if (slot_i == SLOT_W'(b + 1)) sel = data_i[(NUM_BYTES-1-b)*BYTE_W +: BYTE_W];
    end
  end

  assign wr_en_o   = locked_i & valid_i & (slot_i != '0);
  assign wr_data_o = wr_en_o ? sel : '0;
endmodule

// File: rtl/pix_byte_seq.sv
module pix_byte_seq #(
  parameter int PIX_W  = pixseq_pkg::PIX_W_DEF,
  parameter int BYTE_W = pixseq_pkg::BYTE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_clk_i,
  input  logic [PIX_W-1:0]  pix_data_i,
  input  logic              pix_valid_i,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              wr_en_o
);
  localparam int NUM_BYTES = pixseq_pkg::bytes_per_pix(PIX_W, BYTE_W);
  localparam int SLOTS     = NUM_BYTES + 1;
  localparam int SLOT_W    = $clog2(SLOTS);

  logic              locked;
  logic [SLOT_W-1:0] slot;
  logic              capture;
  logic [PIX_W-1:0]  hold_data;
  logic              hold_valid;

  pixseq_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pix_clk_i (pix_clk_i),
    .locked_o  (locked),
    .slot_o    (slot),
    .capture_o (capture)
  );

  pixseq_hold #(.PIX_W(PIX_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (capture),
    .pix_data_i  (pix_data_i),
    .pix_valid_i (pix_valid_i),
    .data_o      (hold_data),
    .valid_o     (hold_valid)
  );

  pixseq_byte_sel #(
    .PIX_W(PIX_W), .BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .SLOT_W(SLOT_W)
  ) u_sel (
    .locked_i  (locked),
    .slot_i    (slot),
    .data_i    (hold_data),
    .valid_i   (hold_valid),
    .wr_data_o (wr_data_o),
    .wr_en_o   (wr_en_o)
  );

  p_idle_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_clk_i && !$past(pix_clk_i)) |-> !wr_en_o);

  p_first_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> wr_data_o == $past(pix_data_i[PIX_W-1 -: BYTE_W]));

  p_valid_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o) |-> $past(pix_valid_i));

  if (NUM_BYTES == 3) begin : g_run3
    p_burst_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_o && $past(wr_en_o) && $past(wr_en_o, 2)) |=> !wr_en_o);
  end
endmodule

// File: tb/pix_byte_seq_bench.sv
module pix_byte_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_clk = 1'b0;
  logic [23:0] pix_data = '0;
  logic        pix_valid = 1'b0;
  logic [7:0]  wr_data;
  logic        wr_en;

  int   checks = 0;
  int   errors = 0;
  int   phase = 3;
  bit   done = 1'b0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  pix_byte_seq u_pix_byte_seq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pix_clk_i   (pix_clk),
    .pix_data_i  (pix_data),
    .pix_valid_i (pix_valid),
    .wr_data_o   (wr_data),
    .wr_en_o     (wr_en)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // driver: one pixel period, pushes expected bytes
  task automatic send_pixel(input logic [23:0] d, input bit v);
    phase = 0; pix_clk = 1'b1; pix_data = d; pix_valid = v;
    if (v) begin
      exp_q.push_back(d[23:16]);
      exp_q.push_back(d[15:8]);
      exp_q.push_back(d[7:0]);
    end
    step();
    phase = 1; pix_data = ~d ^ 24'h5A5A5A; pix_valid = ~v;  // junk for R4
    step();
    phase = 2; pix_clk = 1'b0;
    step();
    phase = 3;
    step();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: %0d bytes still pending at period end, expected 0", exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (wr_en) begin
        checks++;
        if (phase == 0) begin
          errors++;
          $display("FAIL R3: strobe in idle slot, actual 1 expected 0");
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5: unexpected write data %02h, expected no write", wr_data);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          if (wr_data !== e) begin
            errors++;
            $display("FAIL R1: byte actual %02h expected %02h", wr_data, e);
          end
        end
      end else if (wr_data !== 8'h00) begin
        checks++;
        errors++;
        $display("FAIL R8: data with strobe low actual %02h expected 00", wr_data);
      end
    end
  end

  task automatic check_reset_outputs();
    @(negedge clk);
    checks++;
    if (wr_en !== 1'b0 || wr_data !== 8'h00) begin
      errors++;
      $display("FAIL R6: in reset en/data actual %b/%02h expected 0/00", wr_en, wr_data);
    end
  endtask

  initial begin
    logic [23:0] lcg;
    check_reset_outputs();
    step();
    rst_n = 1'b1;
    step();
    step();
    // R1 R2 R4: basic patterns
    send_pixel(24'h123456, 1'b1);
    send_pixel(24'hFFFFFF, 1'b1);
    send_pixel(24'h000000, 1'b1);
    send_pixel(24'hA5C33C, 1'b1);
    // R5: valid low writes nothing
    send_pixel(24'hDEADBE, 1'b0);
    send_pixel(24'h800001, 1'b1);
    send_pixel(24'h0F0F0F, 1'b0);
    send_pixel(24'h0F0F0F, 1'b0);
    lcg = 24'h13579B;
    for (int i = 0; i < 12; i++) begin
      lcg = lcg * 24'd1103 + 24'd12345;
      send_pixel(lcg, (i % 3) != 2);
    end
    // R6: reset mid-period with pixel clock high, released while still high
    phase = 1; pix_clk = 1'b1; pix_data = 24'h777777; pix_valid = 1'b1;
    rst_n = 1'b0;
    check_reset_outputs();
    step();
    check_reset_outputs();
    rst_n = 1'b1;
    step();
    step();
    phase = 2; pix_clk = 1'b0;
    step();
    phase = 3;
    step();
    step();  // extra low cycle shifts the pixel phase: R7 realign
    send_pixel(24'hC0FFEE, 1'b1);
    send_pixel(24'h010203, 1'b1);
    send_pixel(24'h55AA55, 1'b0);
    send_pixel(24'hFEDCBA, 1'b1);
    step();
    done = 1'b1;
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d bytes never written, expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule